// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

The block keeps recently used virtual-to-physical translations for 4 KB pages, so that most memory references skip the multi-level table walk. A requester presents a 36-bit virtual page number with the access kind: write or read, user or supervisor. One cycle later the block answers with a hit and a 40-bit frame number, with a miss, or with a protection fault. A fault is a hit whose cached permission bits forbid the access. It is not a miss. A hardware walker fills in missing translations through a refill port. The refill overwrites an entry that already holds the same page. Otherwise it takes the lowest free way, and when the set is full it takes the way a tree pseudo-LRU points at.

Two maintenance operations keep the cache coherent with the tables in memory. Loading a new top-level table base drops every translation. A single-page invalidate drops only the entry for one page number. Either operation wins over a refill in the same cycle.

The response path is a small state machine with states RS_IDLE, RS_HIT, RS_MISS and RS_FAULT. Each clock it moves to RS_IDLE when no lookup is presented. It moves to RS_MISS when no valid way matches, or when a write hits a writable entry whose dirty bit is clear. It moves to RS_FAULT when a matching entry forbids the access. It moves to RS_HIT in every other case. The output process decodes the current state into the response pins.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid and rsp_valid, rsp_hit, rsp_fault and rsp_pfn are all zero; a lookup after reset misses.
- R2: rsp_valid is high in exactly the cycle after a cycle with lk_req high, and low otherwise.
- R3: A lookup whose set index (vpn bits 3:0) and tag (vpn bits 35:4) match a valid entry, and whose access is permitted, returns rsp_hit=1, rsp_fault=0 and that entry's frame number.
- R4: A lookup with no matching valid entry returns rsp_hit=0, rsp_fault=0 and rsp_pfn=0.
- R5: A matching lookup with lk_user=1 on an entry whose user bit is 0, or with lk_write=1 on an entry whose write bit is 0, returns rsp_hit=1, rsp_fault=1 and the entry's frame number.
- R6: A write lookup that matches a writable entry whose dirty bit is 0 returns rsp_hit=0, rsp_fault=0 (a miss), so the walker can refill it with the dirty bit set.
- R7: A cycle with base_load high clears every valid bit; later lookups miss until refilled.
- R8: inval_en clears only the valid entry whose set and tag match inval_vpn; all other entries keep hitting.
- R9: A refill presented in the same cycle as base_load or inval_en is discarded; a lookup of that page afterwards misses.
- R10: A refill writes the way already holding the same tag if there is one, else the lowest-numbered invalid way, else the pseudo-LRU victim; a set never holds two valid entries with the same tag.
- R11: Each set keeps a 3-bit tree: the root selects ways 0-1 (0) or 2-3 (1), a left bit selects way 0 (0) or 1 (1), a right bit selects way 2 (0) or 3 (1). A lookup answered with rsp_hit=1 and each refill point the bits on its path away from the way used, the hit first and then the refill.
- R12: A lookup sees the contents held before its own cycle: a refill, flush or invalidate in the same cycle takes effect only for later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 36 | Lookup virtual page number |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup comes from user mode |
| fill_en | input | 1 | Refill from the walker |
| fill_vpn | input | 36 | Refill virtual page number |
| fill_pfn | input | 40 | Refill physical frame number |
| fill_user | input | 1 | Refill user-accessible bit |
| fill_write | input | 1 | Refill writable bit |
| fill_dirty | input | 1 | Refill dirty bit |
| base_load | input | 1 | Top-level table base loaded: flush all |
| inval_en | input | 1 | Single-page invalidate |
| inval_vpn | input | 36 | Page number to invalidate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found (including faulting hits) |
| rsp_fault | output | 1 | Protection fault on a hit |
| rsp_pfn | output | 40 | Frame number on a hit, zero on a miss |

## Verification
On every cycle the assertions check the one-cycle response timing and that a fault only ever comes with a hit. They also check that a miss carries a zero frame, that a set never holds two matching ways, and that a lookup right after a flush, an invalidate or a refill of the same page misses or hits as required. The choice of victim way, the ordering of hit and refill updates in the pseudo-LRU tree, the dirty-bit miss and the refills dropped under maintenance depend on a history of operations. Only the bench's reference model can show them, and it compares the responses every clock through directed and mixed traffic.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // Response state of the lookup pipeline
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_HIT   = 2'd1,
        RS_MISS  = 2'd2,
        RS_FAULT = 2'd3
    } rsp_state_e;

endpackage

// File: rtl/xlat_way_match.sv
// Compares a tag against every way of one set.
module xlat_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 32,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            way_vld,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]           key,
    output logic [WAYS-1:0]            hit_vec,
    output logic [WAY_W-1:0]           hit_way
);

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = way_vld[w] && (way_tag[w] == key);
        end
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/xlat_victim_pick.sv
// Chooses the refill way: lowest invalid way, else the tree pseudo-LRU leaf.
module xlat_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int TREE_W = WAYS - 1
) (
    input  logic [WAYS-1:0]   way_vld,
    input  logic [TREE_W-1:0] tree,
    output logic [WAY_W-1:0]  victim
);

    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] tree_way;
    logic             any_free;

    always_comb begin
        free_way = '0;
        any_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_vld[w]) begin
                free_way = WAY_W'(w);
                any_free = 1'b1;
            end
        end
    end

    // Walk from the root, following each node bit to its child
    always_comb begin
        int  cur;
        logic b;
        cur = 0;
        for (int lv = 0; lv < WAY_W; lv++) begin
            b = 1'b0;
            for (int n = 0; n < TREE_W; n++) begin
                if (n == cur) b = tree[n];
            end
            cur = 2 * cur + 1 + (b ? 1 : 0);
        end
        tree_way = WAY_W'(cur - TREE_W);
    end

    assign victim = any_free ? free_way : tree_way;

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int VPN_W = 36,
    parameter int PFN_W = 40,
    parameter int SETS  = 16,
    parameter int WAYS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_write,
    input  logic             lk_user,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_user,
    input  logic             fill_write,
    input  logic             fill_dirty,
    input  logic             base_load,
    input  logic             inval_en,
    input  logic [VPN_W-1:0] inval_vpn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic [PFN_W-1:0] rsp_pfn
);
    import xlat_pkg::*;

    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = VPN_W - IDX_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TREE_W = WAYS - 1;

    // Entry storage
    logic [WAYS-1:0]             vld_q  [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_q  [SETS];
    logic [WAYS-1:0][PFN_W-1:0]  pfn_q  [SETS];
    logic [WAYS-1:0]             usr_q  [SETS];
    logic [WAYS-1:0]             wr_q   [SETS];
    logic [WAYS-1:0]             dty_q  [SETS];
    logic [TREE_W-1:0]           plru_q [SETS];

    // Point every node on the path to way w away from it
    function automatic logic [TREE_W-1:0] tree_touch(
        input logic [TREE_W-1:0] t,
        input logic [WAY_W-1:0]  w
    );
        logic [TREE_W-1:0] r;
        int cur;
        r   = t;
        cur = 0;
        for (int lv = WAY_W - 1; lv >= 0; lv--) begin
            for (int n = 0; n < TREE_W; n++) begin
                if (n == cur) r[n] = ~w[lv];
            end
            cur = 2 * cur + 1 + (w[lv] ? 1 : 0);
        end
        return r;
    endfunction

    // ---------------- lookup path ----------------
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  lk_hvec;
    logic [WAY_W-1:0] lk_way;
    logic             lk_any;

    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];

    xlat_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .way_vld (vld_q[lk_idx]),
        .way_tag (tag_q[lk_idx]),
        .key     (lk_tag),
        .hit_vec (lk_hvec),
        .hit_way (lk_way)
    );
    assign lk_any = |lk_hvec;

    logic ent_usr, ent_wr, ent_dty;
    logic perm_bad, dirty_need;
    assign ent_usr    = usr_q[lk_idx][lk_way];
    assign ent_wr     = wr_q[lk_idx][lk_way];
    assign ent_dty    = dty_q[lk_idx][lk_way];
    assign perm_bad   = (lk_user && !ent_usr) || (lk_write && !ent_wr);
    assign dirty_need = lk_write && ent_wr && !ent_dty;

    // ---------------- refill path ----------------
    logic [IDX_W-1:0] fill_idx;
    logic [TAG_W-1:0] fill_tag;
    logic [WAYS-1:0]  fill_hvec;
    logic [WAY_W-1:0] fill_hway;
    logic [WAY_W-1:0] fill_victim;
    logic [WAY_W-1:0] fill_way;
    logic             fill_take;

    assign fill_idx = fill_vpn[IDX_W-1:0];
    assign fill_tag = fill_vpn[VPN_W-1:IDX_W];

    xlat_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_match (
        .way_vld (vld_q[fill_idx]),
        .way_tag (tag_q[fill_idx]),
        .key     (fill_tag),
        .hit_vec (fill_hvec),
        .hit_way (fill_hway)
    );

    xlat_victim_pick #(.WAYS(WAYS)) u_victim (
        .way_vld (vld_q[fill_idx]),
        .tree    (plru_q[fill_idx]),
        .victim  (fill_victim)
    );

    assign fill_way  = (|fill_hvec) ? fill_hway : fill_victim;
    assign fill_take = fill_en && !base_load && !inval_en;

    // ---------------- invalidate path ----------------
    logic [IDX_W-1:0] inv_idx;
    logic [TAG_W-1:0] inv_tag;
    logic [WAYS-1:0]  inv_hvec;
    logic [WAY_W-1:0] inv_way;

    assign inv_idx = inval_vpn[IDX_W-1:0];
    assign inv_tag = inval_vpn[VPN_W-1:IDX_W];

    xlat_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_inv_match (
        .way_vld (vld_q[inv_idx]),
        .way_tag (tag_q[inv_idx]),
        .key     (inv_tag),
        .hit_vec (inv_hvec),
        .hit_way (inv_way)
    );

    // ---------------- response state machine ----------------
    rsp_state_e state_q, state_d;
    logic [PFN_W-1:0] pfn_hold_q;
    logic             counts_hit;

    always_comb begin
        if (!lk_req)         state_d = RS_IDLE;
        else if (!lk_any)    state_d = RS_MISS;
        else if (perm_bad)   state_d = RS_FAULT;
        else if (dirty_need) state_d = RS_MISS;
        else                 state_d = RS_HIT;
    end

    assign counts_hit = (state_d == RS_HIT) || (state_d == RS_FAULT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pfn_hold_q <= '0;
        else if (counts_hit) pfn_hold_q <= pfn_q[lk_idx][lk_way];
        else                 pfn_hold_q <= '0;
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_fault = 1'b0;
        rsp_pfn   = '0;
        unique case (state_q)
            RS_IDLE: ;
            RS_MISS: rsp_valid = 1'b1;
            RS_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_pfn   = pfn_hold_q;
            end
            RS_FAULT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_fault = 1'b1;
                rsp_pfn   = pfn_hold_q;
            end
        endcase
    end

    // ---------------- valid bits and replacement trees ----------------
    logic [TREE_W-1:0] tree_after_hit;
    assign tree_after_hit = (counts_hit && (lk_idx == fill_idx))
                          ? tree_touch(plru_q[fill_idx], lk_way)
                          : plru_q[fill_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]  <= '0;
                plru_q[s] <= '0;
            end
        end else begin
            if (counts_hit) plru_q[lk_idx] <= tree_touch(plru_q[lk_idx], lk_way);
            if (fill_take) begin
                vld_q[fill_idx][fill_way] <= 1'b1;
                plru_q[fill_idx]          <= tree_touch(tree_after_hit, fill_way);
            end
            if (base_load) begin
                for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
            end else if (inval_en && (|inv_hvec)) begin
                vld_q[inv_idx][inv_way] <= 1'b0;
            end
        end
    end

    // Payload fields: written only by a taken refill
    always_ff @(posedge clk) begin
        if (fill_take) begin
            tag_q[fill_idx][fill_way] <= fill_tag;
            pfn_q[fill_idx][fill_way] <= fill_pfn;
            usr_q[fill_idx][fill_way] <= fill_user;
            wr_q[fill_idx][fill_way]  <= fill_write;
            dty_q[fill_idx][fill_way] <= fill_dirty;
        end
    end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VPN_W = 36,
    parameter int PFN_W = 40,
    parameter int WAYS  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_write,
    input logic             lk_user,
    input logic             fill_en,
    input logic [VPN_W-1:0] fill_vpn,
    input logic [PFN_W-1:0] fill_pfn,
    input logic             base_load,
    input logic             inval_en,
    input logic [VPN_W-1:0] inval_vpn,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_fault,
    input logic [PFN_W-1:0] rsp_pfn,
    input logic [WAYS-1:0]  lk_hvec
);

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    assert_miss_zero_pfn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0));

    assert_fault_is_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_hit && rsp_valid));

    assert_flush_then_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        base_load ##1 lk_req |=> (rsp_valid && !rsp_hit));

    assert_inval_then_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inval_en ##1 (lk_req && (lk_vpn == $past(inval_vpn))) |=> !rsp_hit);

    assert_fill_then_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !base_load && !inval_en) ##1
        (lk_req && !lk_write && !lk_user && (lk_vpn == $past(fill_vpn)))
        |=> (rsp_hit && (rsp_pfn == $past(fill_pfn, 2))));

    assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hvec));

endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .WAYS(WAYS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_vpn    (lk_vpn),
    .lk_write  (lk_write),
    .lk_user   (lk_user),
    .fill_en   (fill_en),
    .fill_vpn  (fill_vpn),
    .fill_pfn  (fill_pfn),
    .base_load (base_load),
    .inval_en  (inval_en),
    .inval_vpn (inval_vpn),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_fault (rsp_fault),
    .rsp_pfn   (rsp_pfn),
    .lk_hvec   (lk_hvec)
);

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 0, lk_write = 0, lk_user = 0;
    logic [35:0] lk_vpn = '0;
    logic        fill_en = 0, fill_user = 0, fill_write = 0, fill_dirty = 0;
    logic [35:0] fill_vpn = '0;
    logic [39:0] fill_pfn = '0;
    logic        base_load = 0, inval_en = 0;
    logic [35:0] inval_vpn = '0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [39:0] rsp_pfn;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    xlat_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_write(lk_write), .lk_user(lk_user),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_user(fill_user), .fill_write(fill_write), .fill_dirty(fill_dirty),
        .base_load(base_load), .inval_en(inval_en), .inval_vpn(inval_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn)
    );

    // ---------------- reference model ----------------
    bit          m_vld [16][4];
    logic [31:0] m_tag [16][4];
    logic [39:0] m_pfn [16][4];
    bit          m_u [16][4];
    bit          m_w [16][4];
    bit          m_d [16][4];
    int          t_root [16];
    int          t_left [16];
    int          t_right [16];

    function automatic int find(input int s, input logic [31:0] t);
        int r = -1;
        for (int w = 0; w < 4; w++) if (m_vld[s][w] && m_tag[s][w] == t) r = w;
        return r;
    endfunction

    function automatic void touch(input int s, input int w);
        t_root[s] = (w < 2) ? 1 : 0;
        if (w < 2) t_left[s]  = (w == 0) ? 1 : 0;
        else       t_right[s] = (w == 2) ? 1 : 0;
    endfunction

    task automatic compare(input string tag, input bit ev, input bit eh, input bit ef,
                           input logic [39:0] ep);
        total++;
        if (rsp_valid !== ev || rsp_hit !== eh || rsp_fault !== ef || rsp_pfn !== ep) begin
            bad++;
            $display("FAIL %s: got v=%0b h=%0b f=%0b pfn=%h expected v=%0b h=%0b f=%0b pfn=%h",
                     tag, rsp_valid, rsp_hit, rsp_fault, rsp_pfn, ev, eh, ef, ep);
        end
    endtask

    // One clock: predict from the pre-edge model state, update it, then compare
    task automatic step(input string tag);
        int idx, hw, fi, fw, ii, iw;
        bit e_v, e_h, e_f;
        logic [39:0] e_p;
        idx = int'(lk_vpn[3:0]);
        hw  = find(idx, lk_vpn[35:4]);
        e_v = lk_req; e_h = 0; e_f = 0; e_p = '0;
        if (lk_req && hw >= 0) begin
            if ((lk_user && !m_u[idx][hw]) || (lk_write && !m_w[idx][hw])) begin
                e_h = 1; e_f = 1; e_p = m_pfn[idx][hw];
            end else if (!(lk_write && !m_d[idx][hw])) begin
                e_h = 1; e_p = m_pfn[idx][hw];
            end
        end
        fi = int'(fill_vpn[3:0]);
        fw = find(fi, fill_vpn[35:4]);
        if (fw < 0) for (int w = 3; w >= 0; w--) if (!m_vld[fi][w]) fw = w;
        if (fw < 0) fw = (t_root[fi] == 0) ? (t_left[fi] != 0 ? 1 : 0) : (t_right[fi] != 0 ? 3 : 2);
        ii = int'(inval_vpn[3:0]);
        iw = find(ii, inval_vpn[35:4]);
        if (e_h) touch(idx, hw);
        if (fill_en && !base_load && !inval_en) begin
            m_vld[fi][fw] = 1; m_tag[fi][fw] = fill_vpn[35:4]; m_pfn[fi][fw] = fill_pfn;
            m_u[fi][fw] = fill_user; m_w[fi][fw] = fill_write; m_d[fi][fw] = fill_dirty;
            touch(fi, fw);
        end
        if (base_load) begin
            for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
        end else if (inval_en && iw >= 0) m_vld[ii][iw] = 0;
        @(posedge clk);
        #1;
        compare(tag, e_v, e_h, e_f, e_p);
    endtask

    task automatic quiet();
        lk_req = 0; lk_write = 0; lk_user = 0; fill_en = 0; base_load = 0; inval_en = 0;
    endtask

    task automatic fill(input logic [35:0] v, input logic [39:0] p, input bit u, input bit w,
                        input bit d, input string tag);
        quiet();
        fill_en = 1; fill_vpn = v; fill_pfn = p; fill_user = u; fill_write = w; fill_dirty = d;
        step(tag);
        quiet();
    endtask

    task automatic look(input logic [35:0] v, input bit w, input bit u, input string tag);
        quiet();
        lk_req = 1; lk_vpn = v; lk_write = w; lk_user = u;
        step(tag);
        quiet();
        step(tag);
    endtask

    function automatic logic [35:0] mk(input int tg, input int s);
        return {32'(tg), 4'(s)};
    endfunction

    initial begin
        for (int s = 0; s < 16; s++) begin
            t_root[s] = 0; t_left[s] = 0; t_right[s] = 0;
            for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        compare("R1 in reset", 0, 0, 0, '0);
        rst_n = 1;
        step("R1 idle after reset");
        look(mk(7, 3), 0, 0, "R1 lookup after reset misses");

        // R3 basic hit, R4 miss on other tag
        fill(mk(7, 3), 40'h12_3456_789A, 1, 1, 1, "R3 refill");
        look(mk(7, 3), 0, 1, "R3 user read hit");
        look(mk(7, 3), 1, 0, "R3 write hit");
        look(mk(8, 3), 0, 0, "R4 other tag miss");
        look(mk(7, 4), 0, 0, "R4 other set miss");

        // R5 protection faults
        fill(mk(9, 6), 40'hAB_CDEF_0123, 0, 0, 1, "R5 refill kernel read-only");
        look(mk(9, 6), 0, 1, "R5 user access faults");
        look(mk(9, 6), 1, 0, "R5 write faults");
        look(mk(9, 6), 0, 0, "R5 kernel read hits");

        // R6 dirty miss, then refresh same tag (R10)
        fill(mk(2, 8), 40'h00_0000_0003, 1, 1, 0, "R6 refill clean");
        look(mk(2, 8), 1, 1, "R6 write to clean misses");
        look(mk(2, 8), 0, 1, "R6 read to clean hits");
        fill(mk(2, 8), 40'h00_0000_0003, 1, 1, 1, "R10 refill same tag dirty");
        look(mk(2, 8), 1, 1, "R10 write hit after dirty refill");

        // R10/R11 fill a set beyond capacity
        for (int t = 0; t < 4; t++) fill(mk(20 + t, 5), 40'(100 + t), 1, 1, 1, "R10 fill free way");
        look(mk(20, 5), 0, 0, "R11 touch way 0");
        look(mk(22, 5), 0, 0, "R11 touch way 2");
        fill(mk(30, 5), 40'd200, 1, 1, 1, "R11 evict pseudo-LRU victim");
        for (int t = 0; t < 4; t++) look(mk(20 + t, 5), 0, 0, "R11 which way was evicted");
        look(mk(30, 5), 0, 0, "R11 new entry hits");

        // R8 invalidate single page
        quiet(); inval_en = 1; inval_vpn = mk(20, 5); step("R8 invalidate"); quiet();
        look(mk(20, 5), 0, 0, "R8 invalidated misses");
        look(mk(22, 5), 0, 0, "R8 neighbour still hits");
        look(mk(7, 3), 0, 0, "R8 other set still hits");
        fill(mk(40, 5), 40'd300, 1, 1, 1, "R10 refill takes freed way");
        look(mk(40, 5), 0, 0, "R10 refilled page hits");

        // R9 refill dropped under maintenance
        quiet(); fill_en = 1; fill_vpn = mk(50, 9); fill_pfn = 40'd5; fill_user = 1;
        fill_write = 1; fill_dirty = 1; inval_en = 1; inval_vpn = mk(51, 9);
        step("R9 refill with invalidate"); quiet();
        look(mk(50, 9), 0, 0, "R9 dropped refill misses");
        quiet(); fill_en = 1; fill_vpn = mk(52, 10); base_load = 1;
        step("R9 refill with flush"); quiet();
        look(mk(52, 10), 0, 0, "R9 dropped refill misses after flush");

        // R12 same-cycle visibility
        fill(mk(60, 11), 40'd77, 1, 1, 1, "R12 refill");
        quiet(); lk_req = 1; lk_vpn = mk(61, 11); fill_en = 1; fill_vpn = mk(61, 11);
        fill_pfn = 40'd78; fill_user = 1; fill_write = 1; fill_dirty = 1;
        step("R12 lookup with same-cycle refill"); quiet(); step("R12 miss seen");
        look(mk(61, 11), 0, 0, "R12 hit one cycle later");
        quiet(); lk_req = 1; lk_vpn = mk(60, 11); base_load = 1;
        step("R12 lookup with same-cycle flush"); quiet(); step("R12 old contents seen");

        // R7 flush
        look(mk(61, 11), 0, 0, "R7 miss after flush");
        look(mk(9, 6), 0, 0, "R7 all entries gone");

        // Mixed traffic, compared every clock
        for (int i = 0; i < 4000; i++) begin
            lk_req     = ($urandom % 2) == 0;
            lk_vpn     = mk($urandom % 7, $urandom % 3);
            lk_write   = ($urandom % 3) == 0;
            lk_user    = ($urandom % 2) == 0;
            fill_en    = ($urandom % 3) == 0;
            fill_vpn   = mk($urandom % 7, $urandom % 3);
            fill_pfn   = 40'({$urandom, $urandom});
            fill_user  = ($urandom % 4) != 0;
            fill_write = ($urandom % 4) != 0;
            fill_dirty = ($urandom % 2) == 0;
            base_load  = ($urandom % 97) == 0;
            inval_en   = ($urandom % 13) == 0;
            inval_vpn  = mk($urandom % 7, $urandom % 3);
            step("mixed R2 R3 R5 R6 R10 R11");
        end
        quiet();
        step("R2 final idle");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule